// File: doc/BRIEF.md
# Processor External Interrupt Pin Conditioner

This block sits between a handful of asynchronous board-level control pins and the core. It turns them into clean internal requests. Each pin is first brought into the block clock domain through two flops. It is then compared with a register that holds the level seen one cycle earlier. The block acts only on a real change of level. A sample that repeats the stored level does nothing, so a held pin never fires a second time.

Each pin has its own sensitivity:

- External interrupt, system-management interrupt and soft reset are level sensitive, active high. Each sets a pending bit to the new level when it changes.
- Machine check reacts only to a falling change. The pending bit it sets stays latched until it is acknowledged.
- Checkstop is active low. It raises a halt request that only the block reset removes.
- Hard reset is active low. Its falling change gives a one-cycle reset request.
- Time-base enable is active high. It starts and freezes the time base.

A per-bit acknowledge lets the core clear pending bits. A summary request tells the core that any bit is pending.

Top module: `pin_conditioner`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `pend_o`, `hard_irq_o`, `tb_en_o`, `halt_o` and `reset_req_o` are all 0.
- R2: A level present on `pins_i` before clock edge k is acted on at edge k+2; the outputs show the result after that edge.
- R3: Pins 0 (external interrupt) and 1 (system-management interrupt) are active high. On a change of level, `pend_o[0]` and `pend_o[1]` take the new level.
- R4: Pin 2 (machine check) sets `pend_o[2]` on a 1-to-0 change only. A 0-to-1 change leaves the bit as it is.
- R5: `ack_i[b]` clears `pend_o[b]` at the next edge, unless a change on that bit's pin is acted on at the same edge. In that case the pin wins. For machine check, a falling change plus ack leaves the bit set.
- R6: Pin 5 (soft reset) is active high. On a change of level, `pend_o[3]` takes the new level.
- R7: `hard_irq_o` is 1 exactly when at least one bit of `pend_o` is 1.
- R8: A 1-to-0 change on pin 3 (checkstop, active low) sets `halt_o`. `halt_o` then stays 1 whatever the pin does, until `rst_n` is low.
- R9: A 1-to-0 change on pin 4 (hard reset, active low) gives a one-cycle pulse on `reset_req_o`. Holding the pin low gives no further pulse.
- R10: Pin 6 (time-base enable) is active high. On a change of level, `tb_en_o` takes the new level.
- R11: A sample that equals the stored level causes no action. For example, after a pending bit is acknowledged while its pin stays at the active level, the bit stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 7 | Asynchronous control pins: 0 ext irq, 1 smi, 2 machine check, 3 checkstop_n, 4 hard reset_n, 5 soft reset, 6 time-base enable |
| ack_i | input | 4 | Per-bit clear for `pend_o` |
| pend_o | output | 4 | Pending bits: 0 ext, 1 smi, 2 machine check, 3 soft reset |
| hard_irq_o | output | 1 | Any pending bit set |
| tb_en_o | output | 1 | Time base running |
| halt_o | output | 1 | Sticky stop request |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The interesting collision is an acknowledge that clears a pending bit at the same edge where a new pin change for that bit is acted on. The bench provokes it by driving a machine-check falling edge and raising `ack_i[2]` exactly two cycles later. The reference model then expects the bit to stay set. A second case acknowledges a level-driven bit while its pin stays high and expects the bit to remain clear afterwards, since no new change occurs.

// File: rtl/pin_conditioner.sv
module pin_conditioner (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] pins_i,
  input  logic [3:0] ack_i,
  output logic [3:0] pend_o,
  output logic       hard_irq_o,
  output logic       tb_en_o,
  output logic       halt_o,
  output logic       reset_req_o
);
  localparam int P_EXT  = 0;
  localparam int P_SMI  = 1;
  localparam int P_MCK  = 2;
  localparam int P_STOP = 3;
  localparam int P_HRST = 4;
  localparam int P_SRST = 5;
  localparam int P_TBEN = 6;

  logic [6:0] meta, smp, last;
  logic [6:0] chg;
  logic [3:0] upd, val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      smp  <= '0;
      last <= '0;
    end else begin
      meta <= pins_i;
      smp  <= meta;
      last <= smp;
    end
  end

  assign chg = smp ^ last;

  assign upd = {chg[P_SRST], chg[P_MCK] & ~smp[P_MCK], chg[P_SMI], chg[P_EXT]};
  assign val = {smp[P_SRST], 1'b1, smp[P_SMI], smp[P_EXT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o      <= '0;
      tb_en_o     <= 1'b0;
      halt_o      <= 1'b0;
      reset_req_o <= 1'b0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (upd[b])        pend_o[b] <= val[b];
        else if (ack_i[b]) pend_o[b] <= 1'b0;
      end
      if (chg[P_TBEN])                 tb_en_o <= smp[P_TBEN];
      if (chg[P_STOP] & ~smp[P_STOP])  halt_o  <= 1'b1;
      reset_req_o <= chg[P_HRST] & ~smp[P_HRST];
    end
  end

  assign hard_irq_o = |pend_o;
endmodule

// File: rtl/pin_conditioner_chk.sv
module pin_conditioner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] pins_i,
  input logic [3:0] ack_i,
  input logic [3:0] pend_o,
  input logic       hard_irq_o,
  input logic       tb_en_o,
  input logic       halt_o,
  input logic       reset_req_o
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);

  assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> !reset_req_o);

  assert_mck_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[2] && !ack_i[2]) |=> pend_o[2]);

  assert_tb_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (tb_en_o == $past(pins_i[6], 3)));

  assert_ext_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd3) && $rose(pend_o[0])) |-> $past(pins_i[0], 3));

  assert_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o != 4'd0) |-> hard_irq_o);
endmodule

bind pin_conditioner pin_conditioner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .ack_i(ack_i), .pend_o(pend_o),
  .hard_irq_o(hard_irq_o), .tb_en_o(tb_en_o), .halt_o(halt_o),
  .reset_req_o(reset_req_o)
);

// File: tb/test_pin_conditioner.sv
module test_pin_conditioner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] pins = 7'b0011000;
  logic [3:0] ack = '0;
  logic [3:0] pend_o;
  logic       hard_irq_o, tb_en_o, halt_o, reset_req_o;

  int checks = 0;
  int errors = 0;

  localparam logic [6:0] IDLE = 7'b0011000;

  pin_conditioner i_pin_conditioner (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .ack_i(ack), .pend_o(pend_o),
    .hard_irq_o(hard_irq_o), .tb_en_o(tb_en_o), .halt_o(halt_o),
    .reset_req_o(reset_req_o)
  );

  always #5 clk = ~clk;

  logic [6:0] m1 = '0, m2 = '0, mq = '0;
  logic [3:0] mp = '0;
  logic mtb = 1'b0, mhalt = 1'b0, mrst = 1'b0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  function automatic logic [7:0] pack_out();
    return {mp, |mp, mtb, mhalt, mrst};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got pend/irq/tb/halt/rst=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] p, input logic [3:0] a, input string tag);
    logic [6:0] chg;
    pins = p;
    ack  = a;
    chg  = m2 ^ mq;
    if (chg[0]) mp[0] = m2[0]; else if (a[0]) mp[0] = 1'b0;
    if (chg[1]) mp[1] = m2[1]; else if (a[1]) mp[1] = 1'b0;
    if (chg[2] && !m2[2]) mp[2] = 1'b1; else if (a[2]) mp[2] = 1'b0;
    if (chg[5]) mp[3] = m2[5]; else if (a[3]) mp[3] = 1'b0;
    if (chg[6]) mtb = m2[6];
    if (chg[3] && !m2[3]) mhalt = 1'b1;
    mrst = chg[4] && !m2[4];
    mq = m2; m2 = m1; m1 = p;
    q_exp.push_back(pack_out());
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic hold(input logic [6:0] p, input int n, input string tag);
    for (int i = 0; i < n; i++) step(p, 4'd0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      string t;
      logic [7:0] e;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, {pend_o, hard_irq_o, tb_en_o, halt_o, reset_req_o}, e);
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] p;
    repeat (3) @(negedge clk);
    check("R1", {pend_o, hard_irq_o, tb_en_o, halt_o, reset_req_o}, 8'd0);
    rst_n = 1'b1;
    hold(IDLE, 4, "R1");

    p = IDLE | 7'b0000001;
    hold(p, 4, "R2");
    p = p | 7'b0000010;
    hold(p, 4, "R3");
    p = p & ~7'b0000001;
    hold(p, 4, "R3");
    p = p & ~7'b0000010;
    hold(p, 4, "R7");

    p = p | 7'b0000100;
    hold(p, 4, "R4");
    p = p & ~7'b0000100;
    hold(p, 4, "R4");
    p = p | 7'b0000100;
    hold(p, 4, "R4");
    step(p, 4'b0100, "R5");
    hold(p, 2, "R5");

    p = p & ~7'b0000100;
    step(p, 4'd0, "R5");
    step(p, 4'd0, "R5");
    step(p, 4'b0100, "R5");
    hold(p, 3, "R5");
    step(p, 4'b0100, "R11");
    hold(p, 4, "R11");

    p = p | 7'b0000001;
    hold(p, 4, "R3");
    step(p, 4'b0001, "R11");
    hold(p, 4, "R11");
    p = p & ~7'b0000001;
    hold(p, 4, "R7");

    p = p | 7'b0100000;
    hold(p, 4, "R6");
    p = p & ~7'b0100000;
    hold(p, 4, "R6");

    p = p | 7'b1000000;
    hold(p, 4, "R10");
    p = p & ~7'b1000000;
    hold(p, 4, "R10");

    p = p & ~7'b0010000;
    hold(p, 6, "R9");
    p = p | 7'b0010000;
    hold(p, 4, "R9");

    p = p & ~7'b0001000;
    hold(p, 4, "R8");
    p = p | 7'b0001000;
    hold(p, 4, "R8");

    hold(p, 2, "R8");
    rst_n = 1'b0;
    #1;
    check("R8", {pend_o, hard_irq_o, tb_en_o, halt_o, reset_req_o}, 8'd0);
    @(negedge clk);
    check("R1", {pend_o, hard_irq_o, tb_en_o, halt_o, reset_req_o}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule